// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block moves bytes between memory and an I/O device, or from one memory location to another, without processor involvement. It owns one transfer channel. It takes a transfer request from the device and asks for the bus on a hold-request line. It waits for the grant, then walks a fixed sequence of named states. In those states it drives the address, the read and write strobes, the address-enable and upper-address strobe, and the device acknowledge. The bus is 8 bits wide and addresses are 16 bits. The upper address byte is put on the data bus and latched outside the block on a strobe pulse. Only the lower byte has its own pins.

Software-facing programming is out of scope. The channel is set up through plain configuration inputs: source address, destination address, word count, count direction, transfer type, timing variant, and request/acknowledge polarity. A one-cycle `cfg_load` pulse copies these in while the sequencer is idle, and this arms the channel. The channel stays armed until the transfer ends, either on terminal count or on an external end-of-process input.

States:
- `ST_SI` is idle.
- `ST_S0` holds the bus request until the grant arrives.
- `ST_S1` strobes out the upper address byte.
- `ST_S2`, `ST_S3`, `ST_SW` (wait) and `ST_S4` make up one memory/I/O transfer.
- Memory-to-memory uses a read phase `ST_S11`..`ST_S14` and a write phase `ST_S21`..`ST_S24`.

Transitions:
- SI→S0 on an armed request.
- S0→S1 (or S0→S11) on grant.
- S1→S2.
- S2→S3 with normal timing, or S2→S4/SW with compressed timing.
- S3→S4 when READY is high, otherwise S3→SW.
- SW→S4 once READY is high.
- S4→SI on the last transfer or when the request drops.
- S4→S1 when the upper address byte changes, otherwise S4→S2.
- S11→S12→S13, then S13→S14 once READY is high, then S14→S21→S22→S23.
- S23→S24 once READY is high.
- S24→SI on the last transfer or when the request drops, otherwise S24→S11.

Top module: `dma_seq`

## Requirements
- R1: While armed, an active request (`dreq` equal to `cfg_dreq_hi`) raises `hrq` one clock later. `aen` and all strobes stay inactive until `hlda` has been seen high. A request while not armed leaves `hrq` low.
- R2: With normal timing and READY high, one transfer takes S2, S3, S4. The read strobe is low for 2 cycles (S2, S3) and the write strobe for 1 cycle (S3). A burst of N transfers on one address page keeps `hrq` high for 2+3N cycles.
- R3: With compressed timing, S3 is skipped (S2 then S4). The read and write strobes are each low for 1 cycle per transfer.
- R4: With extended write, the write strobe starts in S2 and is low for 2 cycles per transfer.
- R5: When READY is low at the end of S3 (or at the end of S2 with compressed timing), the sequencer stays in SW with both strobes held low, until a clock edge sees READY high.
- R6: `adstb` is high for exactly one cycle, in S1, S11 or S21. During that cycle `db_out` carries address bits 15..8 and `db_oe` is high. S1 follows S0, and follows S4 only when the low address byte was FF counting up or 00 counting down. `addr_lo` always carries address bits 7..0.
- R7: Each completed transfer steps the source address by +1 or −1 (`cfg_down`) and decrements the word count. A transfer that starts with count 0 is the last: `eop_out_n` goes low for one cycle in its S4/S24, the channel disarms and `hrq` drops. So a loaded count of C gives C+1 transfers.
- R8: `eop_in_n` low in any non-idle cycle finishes the current transfer, then returns to SI and disarms, without pulsing `eop_out_n`.
- R9: Memory-to-memory (`cfg_m2m`=1): memory read in S12, S13, with `db_in` captured on leaving S13. The captured byte is driven on `db_out` while memory write is low in S23 (and S22 with extended write). The write goes to the destination address, which counts up. `dack` stays inactive. The memory read and write strobes are never both low.
- R10: `dack` equals `cfg_dack_hi` in S2, S3, SW and S4, and its inverse otherwise.
- R11: `aen` is high in every state except SI and S0. Any strobe low implies `aen` high.
- R12: With `cfg_to_io`=0 (I/O to memory), the read strobe is `io_rd_n` and the write strobe is `mem_wr_n`. With `cfg_to_io`=1 (memory to I/O), they are `mem_rd_n` and `io_wr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load configuration and arm (accepted in SI only) |
| cfg_src_addr | input | 16 | Start (source) address |
| cfg_dst_addr | input | 16 | Destination address for memory-to-memory |
| cfg_count | input | 16 | Transfer count minus one |
| cfg_down | input | 1 | 1: source address counts down |
| cfg_to_io | input | 1 | 1: memory to I/O, 0: I/O to memory |
| cfg_m2m | input | 1 | 1: memory-to-memory transfer |
| cfg_compressed | input | 1 | Compressed timing |
| cfg_ext_write | input | 1 | Extended write strobe |
| cfg_dreq_hi | input | 1 | Active level of dreq |
| cfg_dack_hi | input | 1 | Active level of dack |
| dreq | input | 1 | Transfer request from device |
| hlda | input | 1 | Bus grant |
| ready | input | 1 | High: memory/device ready |
| eop_in_n | input | 1 | External end of process, active low |
| db_in | input | 8 | Data bus input |
| hrq | output | 1 | Bus request |
| aen | output | 1 | Address enable |
| adstb | output | 1 | Upper address byte strobe |
| dack | output | 1 | Device acknowledge (programmable level) |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| addr_lo | output | 8 | Address bits 7..0 |
| db_out | output | 8 | Data bus output (upper address or held byte) |
| db_oe | output | 1 | Data bus output enable |
| eop_out_n | output | 1 | Terminal-count pulse, active low (open-drain style) |

## Verification
The assertions check, on every cycle:
- the memory read and write strobes are never low together;
- a strobe is never active without `aen`;
- `adstb` and the terminal-count pulse last one cycle;
- the sequencer stays in S0 without a grant and in SW while READY is low;
- compressed timing never enters S3;
- each step moves the count and address by exactly one.

Only the bench scenarios can show the whole-burst behaviour:
- per-transfer strobe widths for each timing variant;
- the extra S1 on a page crossing;
- which strobe pair each transfer type uses;
- that the byte read in a memory-to-memory transfer is the one written;
- that an external end-of-process stops a long burst after one transfer and leaves the channel disarmed.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [3:0] {
        ST_SI,
        ST_S0,
        ST_S1,
        ST_S2,
        ST_S3,
        ST_SW,
        ST_S4,
        ST_S11,
        ST_S12,
        ST_S13,
        ST_S14,
        ST_S21,
        ST_S22,
        ST_S23,
        ST_S24
    } dma_state_e;

    // states in which a memory/I-O transfer owns the device acknowledge
    function automatic logic in_io_xfer(dma_state_e s);
        return (s == ST_S2) || (s == ST_S3) || (s == ST_SW) || (s == ST_S4);
    endfunction

    // states that close one transfer and advance the counters
    function automatic logic is_step(dma_state_e s);
        return (s == ST_S4) || (s == ST_S24);
    endfunction

    // write phase of a memory-to-memory transfer
    function automatic logic in_m2m_write(dma_state_e s);
        return (s == ST_S21) || (s == ST_S22) || (s == ST_S23) || (s == ST_S24);
    endfunction

endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       hlda,
    input  logic       ready,
    input  logic       m2m,
    input  logic       compressed,
    input  logic       last,
    input  logic       page_cross,
    output dma_state_e state
);

    dma_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SI;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SI:  nxt = req ? ST_S0 : ST_SI;
            ST_S0:  begin
                if (hlda) nxt = m2m ? ST_S11 : ST_S1;
            end
            ST_S1:  nxt = ST_S2;
            ST_S2:  begin
                if (!compressed) nxt = ST_S3;
                else             nxt = ready ? ST_S4 : ST_SW;
            end
            ST_S3:  nxt = ready ? ST_S4 : ST_SW;
            ST_SW:  nxt = ready ? ST_S4 : ST_SW;
            ST_S4:  begin
                if (last || !req) nxt = ST_SI;
                else              nxt = page_cross ? ST_S1 : ST_S2;
            end
            ST_S11: nxt = ST_S12;
            ST_S12: nxt = ST_S13;
            ST_S13: nxt = ready ? ST_S14 : ST_S13;
            ST_S14: nxt = ST_S21;
            ST_S21: nxt = ST_S22;
            ST_S22: nxt = ST_S23;
            ST_S23: nxt = ready ? ST_S24 : ST_S23;
            ST_S24: nxt = (last || !req) ? ST_SI : ST_S11;
            default: nxt = ST_SI;
        endcase
    end

    AST_WAIT_FOR_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S0 && !hlda) |=> (state == ST_S0));                     // R1
    AST_WAIT_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SW && !ready) |=> (state == ST_SW));                    // R5
    AST_COMPRESSED_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (compressed && state == ST_S2) |=> (state != ST_S3));                // R3

endmodule

// File: rtl/dma_seq_regs.sv
module dma_seq_regs #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              down,
    input  logic              step,
    input  logic              busy,
    input  logic              eop_act,
    input  logic              latch,
    input  logic [DATA_W-1:0] db_in,
    output logic              armed,
    output logic              tc,
    output logic              last,
    output logic              page_cross,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [DATA_W-1:0] temp
);

    logic [CNT_W-1:0] count;
    logic             eop_seen;

    assign tc   = (count == '0);
    assign last = tc || eop_seen || eop_act;
    assign page_cross = down ? (src_addr[DATA_W-1:0] == '0)
                             : (src_addr[DATA_W-1:0] == '1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
            count    <= '0;
            armed    <= 1'b0;
        end else if (load) begin
            src_addr <= cfg_src;
            dst_addr <= cfg_dst;
            count    <= cfg_count;
            armed    <= 1'b1;
        end else if (step) begin
            src_addr <= down ? src_addr - ADDR_W'(1) : src_addr + ADDR_W'(1);
            dst_addr <= dst_addr + ADDR_W'(1);
            count    <= count - CNT_W'(1);
            if (last) armed <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       eop_seen <= 1'b0;
        else if (!busy)   eop_seen <= 1'b0;
        else if (eop_act) eop_seen <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     temp <= '0;
        else if (latch) temp <= db_in;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count == $past(count) - CNT_W'(1)));                       // R7
    AST_ADDR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !down) |=> (src_addr == $past(src_addr) + ADDR_W'(1)));     // R7
    AST_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && down) |=> (src_addr == $past(src_addr) - ADDR_W'(1)));      // R7

endmodule

// File: rtl/dma_seq_out.sv
module dma_seq_out
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dma_state_e        state,
    input  logic              to_io,
    input  logic              compressed,
    input  logic              ext_write,
    input  logic              dack_hi,
    input  logic              tc,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [DATA_W-1:0] temp,
    output logic              hrq,
    output logic              aen,
    output logic              adstb,
    output logic              dack,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic [DATA_W-1:0] addr_lo,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    output logic              eop_out_n
);

    logic              rd_ph, wr_ph, m_rd, m_wr, dack_act;
    logic [ADDR_W-1:0] cur;

    always_comb begin
        rd_ph = (state == ST_S2) || (state == ST_S3) || (state == ST_SW);
        wr_ph = (state == ST_S3) || (state == ST_SW) ||
                ((state == ST_S2) && (compressed || ext_write));
        m_rd  = (state == ST_S12) || (state == ST_S13);
        m_wr  = (state == ST_S23) || ((state == ST_S22) && ext_write);

        cur      = in_m2m_write(state) ? dst_addr : src_addr;
        dack_act = in_io_xfer(state);

        hrq       = (state != ST_SI);
        aen       = (state != ST_SI) && (state != ST_S0);
        adstb     = (state == ST_S1) || (state == ST_S11) || (state == ST_S21);
        dack      = dack_hi ? dack_act : !dack_act;
        mem_rd_n  = !((rd_ph && to_io) || m_rd);
        io_rd_n   = !(rd_ph && !to_io);
        mem_wr_n  = !((wr_ph && !to_io) || m_wr);
        io_wr_n   = !(wr_ph && to_io);
        addr_lo   = cur[DATA_W-1:0];
        db_out    = adstb ? DATA_W'(cur >> DATA_W) : temp;
        db_oe     = adstb || m_wr;
        eop_out_n = !(is_step(state) && tc);
    end

    AST_MEM_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));                                          // R9
    AST_STROBE_NEEDS_AEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n || !io_rd_n || !io_wr_n) |-> aen);           // R11
    AST_TC_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !eop_out_n |=> eop_out_n);                                           // R7
    AST_ADSTB_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        adstb |=> !adstb);                                                   // R6

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_down,
    input  logic              cfg_to_io,
    input  logic              cfg_m2m,
    input  logic              cfg_compressed,
    input  logic              cfg_ext_write,
    input  logic              cfg_dreq_hi,
    input  logic              cfg_dack_hi,
    input  logic              dreq,
    input  logic              hlda,
    input  logic              ready,
    input  logic              eop_in_n,
    input  logic [DATA_W-1:0] db_in,
    output logic              hrq,
    output logic              aen,
    output logic              adstb,
    output logic              dack,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic [DATA_W-1:0] addr_lo,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    output logic              eop_out_n
);

    dma_state_e        state;
    logic              armed, tc, last, page_cross;
    logic              dreq_act, req, load, step, busy, latch, eop_act;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [DATA_W-1:0] temp;

    assign dreq_act = cfg_dreq_hi ? dreq : !dreq;
    assign req      = dreq_act && armed;
    assign eop_act  = !eop_in_n;
    assign load     = cfg_load && (state == ST_SI);
    assign step     = is_step(state);
    assign busy     = (state != ST_SI);
    assign latch    = (state == ST_S13) && ready;

    dma_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .hlda       (hlda),
        .ready      (ready),
        .m2m        (cfg_m2m),
        .compressed (cfg_compressed),
        .last       (last),
        .page_cross (page_cross),
        .state      (state)
    );

    dma_seq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .cfg_src    (cfg_src_addr),
        .cfg_dst    (cfg_dst_addr),
        .cfg_count  (cfg_count),
        .down       (cfg_down),
        .step       (step),
        .busy       (busy),
        .eop_act    (eop_act),
        .latch      (latch),
        .db_in      (db_in),
        .armed      (armed),
        .tc         (tc),
        .last       (last),
        .page_cross (page_cross),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .temp       (temp)
    );

    dma_seq_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .to_io      (cfg_to_io),
        .compressed (cfg_compressed),
        .ext_write  (cfg_ext_write),
        .dack_hi    (cfg_dack_hi),
        .tc         (tc),
        .src_addr   (src_addr),
        .dst_addr   (dst_addr),
        .temp       (temp),
        .hrq        (hrq),
        .aen        (aen),
        .adstb      (adstb),
        .dack       (dack),
        .mem_rd_n   (mem_rd_n),
        .mem_wr_n   (mem_wr_n),
        .io_rd_n    (io_rd_n),
        .io_wr_n    (io_wr_n),
        .addr_lo    (addr_lo),
        .db_out     (db_out),
        .db_oe      (db_oe),
        .eop_out_n  (eop_out_n)
    );

    AST_AEN_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aen) |-> $past(hlda));                                         // R1
    AST_IDLE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SI && !armed) |=> !hrq);                                // R1

endmodule

// File: tb/test_dma_seq.sv
`timescale 1ns/1ps
module test_dma_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_load, cfg_down, cfg_to_io, cfg_m2m, cfg_compressed;
    logic        cfg_ext_write, cfg_dreq_hi, cfg_dack_hi;
    logic [15:0] cfg_src_addr, cfg_dst_addr, cfg_count;
    logic        dreq, hlda, ready, eop_in_n;
    logic [7:0]  db_in;
    logic        hrq, aen, adstb, dack, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
    logic [7:0]  addr_lo, db_out;
    logic        db_oe, eop_out_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    dma_seq i_dma_seq (.*);

    typedef struct packed {
        logic        to_io, m2m, comp, extw, down, dreq_hi, dack_hi;
        logic [15:0] src, dst, cnt;
        logic [3:0]  rdy_hold;
        logic [7:0]  eop_at;
        logic [7:0]  exp_hrq, exp_rd, exp_wr;
        logic [3:0]  exp_adstb, exp_eop;
        logic [7:0]  exp_dack, exp_hi, exp_lo, exp_last_hi;
    } row_t;

    localparam int NROWS = 10;
    localparam row_t ROWS [NROWS] = '{
        // R2 I/O->mem normal, 3 transfers
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 16'h1234,16'h0000,16'd2, 4'd0,8'd0, 8'd11,8'd6,8'd3,4'd1,4'd1,8'd9,8'h12,8'h34,8'h12},
        // R3 R10 mem->I/O compressed, low-active request and acknowledge
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h2000,16'h0000,16'd3, 4'd0,8'd0, 8'd10,8'd4,8'd4,4'd1,4'd1,8'd8,8'h20,8'h00,8'h20},
        // R4 extended write
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 16'h3000,16'h0000,16'd1, 4'd0,8'd0, 8'd8,8'd4,8'd4,4'd1,4'd1,8'd6,8'h30,8'h00,8'h30},
        // R6 page crossing counting up
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 16'h10FE,16'h0000,16'd3, 4'd0,8'd0, 8'd15,8'd8,8'd4,4'd2,4'd1,8'd12,8'h10,8'hFE,8'h11},
        // R6 R7 page crossing counting down
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 16'h2001,16'h0000,16'd2, 4'd0,8'd0, 8'd12,8'd6,8'd3,4'd2,4'd1,8'd9,8'h20,8'h01,8'h1F},
        // R9 memory to memory, 2 transfers
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 16'h4000,16'h5000,16'd1, 4'd0,8'd0, 8'd17,8'd4,8'd2,4'd4,4'd1,8'd0,8'h40,8'h00,8'h50},
        // R9 R4 memory to memory, extended write
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 16'h40FF,16'h6000,16'd0, 4'd0,8'd0, 8'd9,8'd2,8'd2,4'd2,4'd1,8'd0,8'h40,8'hFF,8'h60},
        // R5 wait states, normal timing
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 16'h0050,16'h0000,16'd0, 4'd3,8'd0, 8'd7,8'd4,8'd3,4'd1,4'd1,8'd5,8'h00,8'h50,8'h00},
        // R8 external end of process in first transfer
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 16'h0700,16'h0000,16'd9, 4'd0,8'd3, 8'd5,8'd2,8'd1,4'd1,4'd0,8'd3,8'h07,8'h00,8'h07},
        // R5 R3 wait state with compressed timing
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 16'h0800,16'h0000,16'd0, 4'd2,8'd0, 8'd5,8'd2,8'd2,4'd1,4'd1,8'd3,8'h08,8'h00,8'h08}
    };

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_row(input int idx, input row_t r);
        int n_hrq = 0, n_aen = 0, n_adstb = 0, n_eop = 0, n_dack = 0;
        int n_memrd = 0, n_memwr = 0, n_iord = 0, n_iowr = 0, n_bad = 0;
        int hold, guard;
        bit seen = 0, got_lo = 0, done = 0;
        logic [7:0] f_hi = 8'h00, l_hi = 8'h00, f_lo = 8'h00;

        @(negedge clk);
        cfg_to_io = r.to_io; cfg_m2m = r.m2m; cfg_compressed = r.comp;
        cfg_ext_write = r.extw; cfg_down = r.down; cfg_dreq_hi = r.dreq_hi;
        cfg_dack_hi = r.dack_hi; cfg_src_addr = r.src; cfg_dst_addr = r.dst;
        cfg_count = r.cnt; dreq = !r.dreq_hi; hlda = 1'b0; eop_in_n = 1'b1;
        hold = int'(r.rdy_hold); ready = (hold == 0);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        dreq = r.dreq_hi;
        for (guard = 0; guard < 300; guard++) begin
            @(negedge clk);
            if (seen && !hrq) begin
                done = 1;
                break;
            end
            if (hrq) begin seen = 1; n_hrq++; end
            if (aen) n_aen++;
            if (adstb) begin
                if (n_adstb == 0) f_hi = db_out;
                l_hi = db_out;
                n_adstb++;
            end
            if (!eop_out_n) n_eop++;
            if (dack == r.dack_hi) n_dack++;
            if (!mem_rd_n) n_memrd++;
            if (!io_rd_n)  n_iord++;
            if (!io_wr_n)  n_iowr++;
            if (!mem_wr_n) begin
                n_memwr++;
                if (r.m2m && !(db_oe && db_out == 8'h3C)) n_bad++;
            end
            if (!got_lo && (!mem_rd_n || !io_rd_n)) begin
                got_lo = 1;
                f_lo = addr_lo;
            end
            hlda = hrq;
            if (!eop_in_n) eop_in_n = 1'b1;
            if (r.eop_at != 0 && n_hrq == int'(r.eop_at)) eop_in_n = 1'b0;
            if (hold > 0 && (!mem_wr_n || !io_wr_n)) begin
                hold--;
                if (hold == 0) ready = 1'b1;
            end
        end
        chk(done, $sformatf("row %0d R7 burst ends (watchdog)", idx), int'(done), 1);
        chk(n_hrq == int'(r.exp_hrq), $sformatf("row %0d R2 hrq cycles", idx), n_hrq, int'(r.exp_hrq));
        chk(n_aen == int'(r.exp_hrq) - 1, $sformatf("row %0d R11 aen cycles", idx), n_aen, int'(r.exp_hrq) - 1);
        chk(n_adstb == int'(r.exp_adstb), $sformatf("row %0d R6 adstb pulses", idx), n_adstb, int'(r.exp_adstb));
        chk(f_hi == r.exp_hi, $sformatf("row %0d R6 first upper byte", idx), int'(f_hi), int'(r.exp_hi));
        chk(l_hi == r.exp_last_hi, $sformatf("row %0d R6 last upper byte", idx), int'(l_hi), int'(r.exp_last_hi));
        chk(f_lo == r.exp_lo, $sformatf("row %0d R6 first low byte", idx), int'(f_lo), int'(r.exp_lo));
        chk(n_eop == int'(r.exp_eop), $sformatf("row %0d R7 tc pulses", idx), n_eop, int'(r.exp_eop));
        chk(n_dack == int'(r.exp_dack), $sformatf("row %0d R10 dack cycles", idx), n_dack, int'(r.exp_dack));
        if (r.m2m) begin
            chk(n_memrd == int'(r.exp_rd) && n_iord == 0, $sformatf("row %0d R9 read cycles", idx), n_memrd, int'(r.exp_rd));
            chk(n_memwr == int'(r.exp_wr) && n_iowr == 0, $sformatf("row %0d R9 write cycles", idx), n_memwr, int'(r.exp_wr));
            chk(n_bad == 0, $sformatf("row %0d R9 held byte written", idx), n_bad, 0);
        end else if (r.to_io) begin
            chk(n_memrd == int'(r.exp_rd) && n_iord == 0, $sformatf("row %0d R12 read strobe", idx), n_memrd, int'(r.exp_rd));
            chk(n_iowr == int'(r.exp_wr) && n_memwr == 0, $sformatf("row %0d R12 write strobe", idx), n_iowr, int'(r.exp_wr));
        end else begin
            chk(n_iord == int'(r.exp_rd) && n_memrd == 0, $sformatf("row %0d R12 read strobe", idx), n_iord, int'(r.exp_rd));
            chk(n_memwr == int'(r.exp_wr) && n_iowr == 0, $sformatf("row %0d R12 write strobe", idx), n_memwr, int'(r.exp_wr));
        end
        // request stays active: channel must be disarmed (R1, R8)
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!hrq, $sformatf("row %0d R8 disarmed after end", idx), int'(hrq), 0);
        end
        dreq = !r.dreq_hi;
        hlda = 1'b0;
        ready = 1'b1;
        eop_in_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_load = 1'b0; cfg_down = 1'b0; cfg_to_io = 1'b0;
        cfg_m2m = 1'b0; cfg_compressed = 1'b0; cfg_ext_write = 1'b0;
        cfg_dreq_hi = 1'b1; cfg_dack_hi = 1'b1; cfg_src_addr = '0;
        cfg_dst_addr = '0; cfg_count = '0; dreq = 1'b0; hlda = 1'b0;
        ready = 1'b1; eop_in_n = 1'b1; db_in = 8'h3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R1, R11, R10)
        chk(!hrq && !aen && !adstb, "R11 reset bus outputs idle", int'({hrq, aen, adstb}), 0);
        chk(mem_rd_n && mem_wr_n && io_rd_n && io_wr_n, "R11 reset strobes high",
            int'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 15);
        chk(eop_out_n && !dack, "R10 reset eop/dack inactive", int'({eop_out_n, dack}), 2);

        // request without arming is ignored (R1)
        dreq = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!hrq, "R1 unarmed request ignored", int'(hrq), 0);
        end
        dreq = 1'b0;

        // grant withheld: bus request only (R1)
        @(negedge clk);
        cfg_src_addr = 16'h0900; cfg_count = 16'd0; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; dreq = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(hrq && !aen && mem_wr_n && io_rd_n, "R1 no bus activity before grant",
                int'({hrq, aen}), 2);
        end
        hlda = 1'b1;
        begin
            bit saw_aen = 0;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (aen) saw_aen = 1;
                if (!hrq) break;
            end
            chk(saw_aen && !hrq, "R1 transfer proceeds after grant", int'(saw_aen), 1);
        end
        dreq = 1'b0; hlda = 1'b0;

        for (int i = 0; i < NROWS; i++) run_row(i, ROWS[i]);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule